// File: doc/BRIEF.md
# Non-Revertive Reference Auto-Selector

This block drives the select line of a two-input reference clock multiplexer. In manual mode the select follows a manual-select input. In automatic mode the block watches a loss-of-lock flag from the PLL. When that flag rises, the block moves to the other reference one time only and reports the new choice on an acknowledge output. After that move it holds its choice and ignores the manual input. It is rearmed only when automatic mode is dropped and then raised again while the loop is locked. Detecting whether a clock is present, and the multiplexer itself, are outside this block.

The mode-enable and manual-select inputs may be asynchronous, so each passes through its own two-flop synchronizer before the controller uses it. The loss-of-lock flag is taken to be synchronous to the block clock. The select is held in a single register, so each trigger changes it exactly once. Reference 0 is selected by a select value of 0 and reference 1 by a value of 1.

Top module: `refsel_autosel`

## Requirements
- R1: While the synchronous active-low reset is applied, and on the first sample after it is released, the select and the acknowledge are both 0 and the block is in manual mode.
- R2: In manual mode (auto input low), the select follows the manual input (0 picks reference 0, 1 picks reference 1). A change on the manual input reaches the select within three clock edges.
- R3: Automatic mode becomes armed only when the synchronized auto input is high and the loss-of-lock flag is low. If auto goes high while the flag is high, the block waits unarmed, keeps following the manual input and never switches, however long the flag stays high. It arms on the first edge at which the flag is low.
- R4: While armed, a loss-of-lock flag of 1 sampled at a clock edge inverts the select at that same edge.
- R5: Only one automatic switch is made per arming. Later rises or falls of the loss-of-lock flag do not change the select until the block is rearmed.
- R6: After an automatic switch, the manual input has no effect on the select for as long as the synchronized auto input stays high.
- R7: Rearming requires the auto input to go low, which returns the block to manual mode where the select follows the manual input, and then high again while the flag is low. After that, a new loss-of-lock event switches the select again.
- R8: The acknowledge output always equals the select output.
- R9: If, at the same edge, the armed block sees the synchronized auto input low and the loss-of-lock flag high, leaving automatic mode wins. No switch is made and the select takes the manual value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| auto_en_i | input | 1 | Automatic mode enable (asynchronous) |
| man_sel_i | input | 1 | Manual reference choice (asynchronous) |
| lock_lost_i | input | 1 | Loss-of-lock flag, 1 = unlocked (synchronous) |
| ref_sel_o | output | 1 | Multiplexer select, 0 = reference 0 |
| ref_ack_o | output | 1 | Reference currently in use |

## Verification
Two events can land on the same clock edge: the end of automatic mode, when the synchronized auto input falls, and the loss-of-lock trigger while the block is armed. The bench lowers the auto input and then raises the flag exactly two cycles later, so both are sampled at one edge. It then checks that the select holds the manual value rather than the inverted one, and that it keeps that value while the flag stays high. A second overlap is also covered: a manual-input change during the switch must not undo the inversion.

// File: rtl/refsel_pkg.sv
// Shared types for the reference auto-selector.
package refsel_pkg;

    // Controller states; encoding is internal to the block.
    typedef enum logic [1:0] {
        ST_MANUAL   = 2'd0,  // auto low: select follows manual input
        ST_WAIT     = 2'd1,  // auto high, loop unlocked: not yet armed
        ST_ARMED    = 2'd2,  // auto high, armed for one switch
        ST_SWITCHED = 2'd3   // switch done: select frozen until auto low
    } refsel_state_e;

endpackage

// File: rtl/refsel_sync.sv
// Multi-stage synchronizer for a bundle of independent level signals.
// Assumes each bit is a slow level; bits are not coherent with each other.
module refsel_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: capture the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= d_i;
            end
        end else begin : g_next
            // Later stages: let metastability resolve.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/refsel_ctrl.sv
// Mode controller: tracks the arming state and decides the next select.
// Assumes auto_s/man_s are synchronized and lock_lost is synchronous.
module refsel_ctrl
    import refsel_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          auto_s,
    input  logic          man_s,
    input  logic          lock_lost,
    input  logic          sel_q,
    output logic          sel_d,
    output refsel_state_e state_o
);

    refsel_state_e state_q, state_d;

    // Next-state and next-select decision; leaving auto mode has top priority.
    always_comb begin
        state_d = state_q;
        sel_d   = man_s;
        unique case (state_q)
            ST_MANUAL: begin
                if (auto_s) state_d = lock_lost ? ST_WAIT : ST_ARMED;
            end
            ST_WAIT: begin
                if (!auto_s)        state_d = ST_MANUAL;
                else if (!lock_lost) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!auto_s) begin
                    state_d = ST_MANUAL;
                end else if (lock_lost) begin
                    state_d = ST_SWITCHED;
                    sel_d   = ~sel_q;
                end
            end
            ST_SWITCHED: begin
                sel_d = sel_q;
                if (!auto_s) state_d = ST_MANUAL;
            end
            default: state_d = ST_MANUAL;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_MANUAL;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/refsel_selreg.sv
// Select register: single flop so a trigger changes the select exactly once.
module refsel_selreg (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_d,
    output logic sel_q
);

    // Hold the reference choice.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel_d;
    end

endmodule

// File: rtl/refsel_autosel.sv
// Top: non-revertive two-reference auto-selector.
// Assumes lock_lost_i is synchronous to clk; auto and manual are not.
module refsel_autosel
    import refsel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en_i,
    input  logic man_sel_i,
    input  logic lock_lost_i,
    output logic ref_sel_o,
    output logic ref_ack_o
);

    localparam int NSYNC = 2;

    logic [NSYNC-1:0] sync_q;
    logic             auto_s, man_s;
    logic             sel_d, sel_q;
    refsel_state_e    fsm_state;

    refsel_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({auto_en_i, man_sel_i}),
        .q_o   (sync_q)
    );

    assign auto_s = sync_q[1];
    assign man_s  = sync_q[0];

    refsel_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_s    (auto_s),
        .man_s     (man_s),
        .lock_lost (lock_lost_i),
        .sel_q     (sel_q),
        .sel_d     (sel_d),
        .state_o   (fsm_state)
    );

    refsel_selreg u_selreg (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_d (sel_d),
        .sel_q (sel_q)
    );

    assign ref_sel_o = sel_q;
    assign ref_ack_o = sel_q;

endmodule

// File: rtl/refsel_autosel_chk.sv
// Checker for the auto-selector, bound to the top module.
module refsel_autosel_chk
    import refsel_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          auto_s,
    input logic          man_s,
    input logic          lock_lost,
    input logic          sel,
    input refsel_state_e state
);

    // R2
    manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MANUAL) |=> (sel == $past(man_s)));

    // R3
    wait_no_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |=> (sel == $past(man_s)));

    // R4
    armed_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && auto_s && lock_lost)
        |=> (sel != $past(sel)) && (state == ST_SWITCHED));

    // R5
    switched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWITCHED) |=> $stable(sel));

    // R7
    rearm_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWITCHED) |=> (state == ST_SWITCHED || state == ST_MANUAL));

    // R9
    exit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !auto_s)
        |=> (state == ST_MANUAL) && (sel == $past(man_s)));

endmodule

bind refsel_autosel refsel_autosel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_s    (auto_s),
    .man_s     (man_s),
    .lock_lost (lock_lost_i),
    .sel       (ref_sel_o),
    .state     (fsm_state)
);

// File: tb/refsel_autosel_test.sv
// Directed bench for the reference auto-selector.
module refsel_autosel_test;

    logic clk = 1'b0;
    logic rst_n, auto_en, man_sel, lock_lost;
    logic ref_sel, ref_ack;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #5 clk = ~clk;

    refsel_autosel uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_en_i   (auto_en),
        .man_sel_i   (man_sel),
        .lock_lost_i (lock_lost),
        .ref_sel_o   (ref_sel),
        .ref_ack_o   (ref_ack)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Select and acknowledge both checked; R8 on every sample.
    task automatic check_sel(input string tag, input logic exp);
        check(tag, ref_sel, exp);
        check("R8 ack", ref_ack, ref_sel);
    endtask

    task automatic do_reset(input logic a, input logic m, input logic l);
        @(negedge clk);
        rst_n = 1'b0; auto_en = a; man_sel = m; lock_lost = l;
        step(3);
        check_sel("R1 in reset", 1'b0);
        rst_n = 1'b1;
        check_sel("R1 after release", 1'b0);
    endtask

    task automatic t_manual();
        do_reset(1'b0, 1'b1, 1'b0);
        step(4);
        check_sel("R2 follow 1", 1'b1);
        man_sel = 1'b0; step(2);
        check_sel("R2 not before sync", 1'b1);
        step(2);
        check_sel("R2 follow 0", 1'b0);
        lock_lost = 1'b1; step(4);
        check_sel("R2 flag ignored manual", 1'b0);
    endtask

    task automatic t_wait();
        do_reset(1'b0, 1'b0, 1'b1);
        auto_en = 1'b1; step(4);
        man_sel = 1'b1; step(4);
        check_sel("R3 waiting follows manual", 1'b1);
        step(10);
        check_sel("R3 no switch while unarmed", 1'b1);
        lock_lost = 1'b0; step(1);
        lock_lost = 1'b1; step(1);
        check_sel("R3 armed on lock then switch", 1'b0);
    endtask

    task automatic t_switch();
        do_reset(1'b0, 1'b0, 1'b0);
        auto_en = 1'b1; step(4);
        check_sel("R4 armed start", 1'b0);
        lock_lost = 1'b1; step(1);
        check_sel("R4 switch one edge", 1'b1);
        step(5);
        check_sel("R5 flag held", 1'b1);
        lock_lost = 1'b0; step(5);
        lock_lost = 1'b1; step(5);
        check_sel("R5 second event ignored", 1'b1);
        lock_lost = 1'b0;
        man_sel = 1'b1; step(4);
        man_sel = 1'b0; step(4);
        check_sel("R6 manual ignored", 1'b1);
    endtask

    task automatic t_rearm();
        do_reset(1'b0, 1'b1, 1'b0);
        auto_en = 1'b1; step(4);
        lock_lost = 1'b1; step(1);
        check_sel("R7 first switch", 1'b0);
        lock_lost = 1'b0;
        auto_en = 1'b0; step(4);
        check_sel("R7 manual after drop", 1'b1);
        auto_en = 1'b1; step(4);
        lock_lost = 1'b1;
        man_sel = 1'b0; step(1);
        check_sel("R7 rearmed switch", 1'b0);
        step(4);
        check_sel("R6 manual during switch", 1'b0);
    endtask

    task automatic t_race();
        do_reset(1'b0, 1'b0, 1'b0);
        auto_en = 1'b1; step(4);
        auto_en = 1'b0; step(2);
        lock_lost = 1'b1; step(1);
        check_sel("R9 exit beats trigger", 1'b0);
        step(4);
        check_sel("R9 stays manual", 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; auto_en = 1'b0; man_sel = 1'b0; lock_lost = 1'b0;
        t_manual();
        t_wait();
        t_switch();
        t_rearm();
        t_race();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule